// File: doc/BRIEF.md
# Register-Programmed SPI Shift Engine

This block is a memory-mapped SPI master. Software sets a clock divider and a transmit word, then writes a shift command. Each command moves between 1 and 32 bits in SPI mode 0. SCK idles low. MOSI changes after each falling SCK edge, and MISO is captured on each rising edge. The received bits collect in a read-only receive register.

The shift command holds four things: a start/busy flag, a chip-select choice for three slaves, a terminate flag and a bit count. A chip select stays low from one command to the next until a command with the terminate flag set finishes. This lets software build a long transaction out of several shifts. While no shift is running, each pin takes the level held in an I/O-control register. When the engine is disabled, it stops any shift in progress and drops any held select.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset the I/O-control register (offset 0x08) reads 0x70000 and the enable bit reads 0. Outside a shift, MOSI follows I/O-control bit 0 and SCK follows bit 8. Each chip select that is not held follows bit 16+i, so after reset all selects are high and SCK and MOSI are low.
- R2: During a shift, SCK starts low. Each SCK phase lasts exactly divider+1 input clocks, where the divider is bits [5:0] of offset 0x04. One SCK period is therefore 2×(divider+1) clocks.
- R3: The data-out word (offset 0x10) is right-aligned, and bit n−1 appears on MOSI first. Each following bit appears after a falling SCK edge, and MOSI is stable while SCK is high.
- R4: At each start, data-in (offset 0x18) is cleared. Each MISO sample enters at bit 0 and shifts the earlier bits upward, so after n bits the first-received bit sits at bit n−1.
- R5: Bit 31 of shift-control (offset 0x14) reads 1 from the clock after a start command until the shift ends. It then returns to 0 by itself, exactly 2×(divider+1)×n clocks after the start.
- R6: During a shift, chip select i is driven low when shift-control bit 28+i of the start command was set.
- R7: When a shift with bit 26 clear ends, its chip selects stay low. When bit 26 is set, they return to their idle level as soon as the last SCK falling edge occurs.
- R8: The bit count is shift-control bits [5:0]. A value of 0 or a value above 32 shifts 32 bits.
- R9: While a shift is running, writes to offsets 0x04, 0x10 and 0x14 are ignored, and a second start does not begin a new shift.
- R10: While the enable bit (offset 0x00 bit 0) is 0, start commands are ignored. Writing 0 to the enable bit during a shift stops the shift at once and releases all held selects.
- R11: Offsets 0x00, 0x04, 0x08, 0x10 and 0x18 read back their contents, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 3 | Active-low chip selects |

## Verification
The assertions check the following on every cycle:
- While disabled, the pins sit at their I/O-control levels.
- MOSI does not move while SCK is high.
- The divider stays frozen during a shift.
- A normal completion always follows a high SCK phase.
- A terminated shift leaves its selects idle.

Other behaviour only the bench scenarios can show:
- The exact phase length for several divider values.
- The order of bits on MOSI and the layout of the received word.
- Chip-select hold across commands, and handover between slaves.
- Count normalization.
- Writes during a shift having no effect.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    localparam int DW     = 32;
    localparam int AW     = 5;
    localparam int DIV_W  = 6;
    localparam int NCS    = 3;
    localparam int CNT_W  = $clog2(DW) + 1;

    localparam logic [AW-1:0] A_ENABLE = 5'h00;
    localparam logic [AW-1:0] A_DIV    = 5'h04;
    localparam logic [AW-1:0] A_IOCTL  = 5'h08;
    localparam logic [AW-1:0] A_TXD    = 5'h10;
    localparam logic [AW-1:0] A_CMD    = 5'h14;
    localparam logic [AW-1:0] A_RXD    = 5'h18;

    localparam int START_BIT = 31;
    localparam int SEL_LSB   = 28;
    localparam int TERM_BIT  = 26;

    localparam int IO_MOSI   = 0;
    localparam int IO_SCK    = 8;
    localparam int IO_CS_LSB = 16;
    localparam logic [DW-1:0] IOCTL_RST = 32'h0007_0000;

    typedef struct packed {
        logic             busy;
        logic             sck;
        logic             term;
        logic [CNT_W-1:0] left;
        logic [DW-1:0]    tx;
        logic [DW-1:0]    rx;
        logic [NCS-1:0]   hold;
    } core_st_t;

    typedef struct packed {
        logic             en;
        logic [DIV_W-1:0] div;
        logic [DW-1:0]    ioctl;
        logic [DW-1:0]    txd;
        logic [DW-1:0]    cmd;
    } regs_t;
endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == div);
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             abort,
    input  logic [CNT_W-1:0] nbits,
    input  logic [DW-1:0]    txword,
    input  logic [NCS-1:0]   sel,
    input  logic             term,
    input  logic             tick,
    input  logic             miso,
    output logic             busy,
    output logic             sck,
    output logic             txbit,
    output logic [DW-1:0]    rxword,
    output logic [NCS-1:0]   hold
);
    core_st_t st_d, st_q;
    logic [CNT_W-1:0] align;

    always_comb begin
        st_d  = st_q;
        align = CNT_W'(DW) - nbits;
        if (abort) begin
            st_d.busy = 1'b0;
            st_d.sck  = 1'b0;
            st_d.hold = '0;
        end else if (start && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.sck  = 1'b0;
            st_d.term = term;
            st_d.left = nbits;
            st_d.tx   = txword << align;
            st_d.rx   = '0;
            st_d.hold = sel;
        end else if (st_q.busy && tick) begin
            if (!st_q.sck) begin
                st_d.sck = 1'b1;
                st_d.rx  = {st_q.rx[DW-2:0], miso};
            end else begin
                st_d.sck = 1'b0;
                if (st_q.left == CNT_W'(1)) begin
                    st_d.busy = 1'b0;
                    if (st_q.term) st_d.hold = '0;
                end else begin
                    st_d.left = st_q.left - 1'b1;
                    st_d.tx   = {st_q.tx[DW-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign sck    = st_q.sck;
    assign txbit  = st_q.tx[DW-1];
    assign rxword = st_q.rx;
    assign hold   = st_q.hold;
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
    import spi_eng_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          spi_sck,
    output logic          spi_mosi,
    input  logic          spi_miso,
    output logic [NCS-1:0] spi_cs_n
);
    regs_t r_d, r_q;
    logic             core_busy, core_sck, core_txbit, tick;
    logic [DW-1:0]    core_rx;
    logic [NCS-1:0]   core_hold;
    logic             start, abort;
    logic [CNT_W-1:0] nbits;
    logic [DW-1:0]    ioctl_w;
    logic [DIV_W-1:0] div_w;
    logic             en_w, term_w;

    always_comb begin
        r_d   = r_q;
        start = 1'b0;
        abort = !r_q.en;
        if (reg_we) begin
            unique case (reg_addr)
                A_ENABLE: begin
                    r_d.en = reg_wdata[0];
                    if (!reg_wdata[0]) abort = 1'b1;
                end
                A_IOCTL: r_d.ioctl = reg_wdata;
                A_DIV:   if (!core_busy) r_d.div = reg_wdata[DIV_W-1:0];
                A_TXD:   if (!core_busy) r_d.txd = reg_wdata;
                A_CMD: if (!core_busy) begin
                    r_d.cmd = reg_wdata;
                    start   = reg_wdata[START_BIT] && r_q.en;
                end
                default: ;
            endcase
        end
        if (reg_wdata[CNT_W-2:0] == '0 || reg_wdata[CNT_W-1:0] > CNT_W'(DW))
            nbits = CNT_W'(DW);
        else
            nbits = reg_wdata[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.ioctl <= IOCTL_RST;
        end else begin
            r_q <= r_d;
        end
    end

    spi_half_timer u_timer (
        .clk(clk), .rst_n(rst_n), .run(core_busy), .div(r_q.div), .tick(tick)
    );

    spi_shift_core u_core (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .nbits(nbits), .txword(r_q.txd),
        .sel(reg_wdata[SEL_LSB +: NCS]), .term(reg_wdata[TERM_BIT]),
        .tick(tick), .miso(spi_miso), .busy(core_busy), .sck(core_sck),
        .txbit(core_txbit), .rxword(core_rx), .hold(core_hold)
    );

    always_comb begin
        unique case (reg_addr)
            A_ENABLE: reg_rdata = {{(DW-1){1'b0}}, r_q.en};
            A_DIV:    reg_rdata = {{(DW-DIV_W){1'b0}}, r_q.div};
            A_IOCTL:  reg_rdata = r_q.ioctl;
            A_TXD:    reg_rdata = r_q.txd;
            A_CMD:    reg_rdata = {core_busy, r_q.cmd[DW-2:0]};
            A_RXD:    reg_rdata = core_rx;
            default:  reg_rdata = '0;
        endcase
    end

    assign spi_sck  = core_busy ? core_sck   : r_q.ioctl[IO_SCK];
    assign spi_mosi = core_busy ? core_txbit : r_q.ioctl[IO_MOSI];

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign spi_cs_n[i] = core_hold[i] ? 1'b0 : r_q.ioctl[IO_CS_LSB + i];
    end

    assign ioctl_w = r_q.ioctl;
    assign div_w   = r_q.div;
    assign en_w    = r_q.en;
    assign term_w  = r_q.cmd[TERM_BIT];
endmodule

// File: rtl/spi_shift_engine_chk.sv
module spi_shift_engine_chk
    import spi_eng_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             en,
    input logic             term,
    input logic             sck,
    input logic             mosi,
    input logic [NCS-1:0]   cs_n,
    input logic [DW-1:0]    ioctl,
    input logic [DIV_W-1:0] div
);
    // R10
    idle_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (sck == ioctl[IO_SCK] && mosi == ioctl[IO_MOSI]
                 && cs_n == ioctl[IO_CS_LSB +: NCS]));

    // R3
    mosi_stable_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && sck && $past(sck)) |-> $stable(mosi));

    // R9
    div_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(div));

    // R5
    end_after_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && en) |-> $past(sck));

    // R7
    term_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && en && term) |-> cs_n == ioctl[IO_CS_LSB +: NCS]);

    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck == ioctl[IO_SCK]);
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .busy(core_busy), .en(en_w), .term(term_w),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n), .ioctl(ioctl_w), .div(div_w)
);

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        we = 1'b0;
    logic [4:0]  addr = 5'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        sck, mosi, miso = 1'b0;
    logic [2:0]  cs_n;
    int checks = 0, errors = 0;
    logic [31:0] cur_dout = '0;
    logic [5:0]  cur_div = '0;

    always #5 clk = ~clk;

    spi_shift_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .spi_cs_n(cs_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); we = 1'b1; addr = a; wdata = d;
        @(negedge clk); we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        addr = a; #1;
        chk(tag, rdata, exp);
    endtask

    // per-cycle reference: phase length h, n bits, expected pins each clock
    task automatic run_shift(input logic [31:0] cmd, input logic [31:0] slv,
                             input logic [2:0] csmask, input bit inject);
        int n, h;
        logic [31:0] mask;
        n = int'(cmd[5:0]);
        if (n == 0 || n > 32) n = 32;
        h = int'(cur_div) + 1;
        mask = (n == 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
        wr(5'h14, cmd);
        for (int k = 0; k < 2 * h * n; k++) begin
            int j;
            j = k / (2 * h);
            miso = slv[n - 1 - j];
            if (inject) begin
                if (k == 2)      begin we = 1'b1; addr = 5'h10; wdata = ~cur_dout; end
                else if (k == 3) begin addr = 5'h14; wdata = 32'h9000_0008; end
                else if (k == 4) begin addr = 5'h04; wdata = 32'h5; end
                else if (k == 5) we = 1'b0;
            end
            #1;
            chk("R2 sck phase", {31'b0, sck}, {31'b0, 1'(((k / h) % 2) == 1)});
            chk("R3 mosi order", {31'b0, mosi}, {31'b0, cur_dout[n - 1 - j]});
            chk("R6 cs during shift", {29'b0, cs_n}, {29'b0, ~csmask});
            @(negedge clk);
        end
        rd_chk("R5 busy cleared", 5'h14, {1'b0, cmd[30:0]});
        chk("R7 cs after shift", {29'b0, cs_n}, cmd[26] ? 32'h7 : {29'b0, ~csmask});
        chk("R2 sck idle", {31'b0, sck}, 32'h0);
        rd_chk("R4 rx word", 5'h18, slv & mask);
        if (inject) begin
            rd_chk("R9 dout kept", 5'h10, cur_dout);
            rd_chk("R9 div kept", 5'h04, {26'b0, cur_div});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_chk("R1 ioctl reset", 5'h08, 32'h0007_0000);
        rd_chk("R1 enable reset", 5'h00, 32'h0);
        chk("R1 cs idle", {29'b0, cs_n}, 32'h7);
        chk("R1 sck idle", {31'b0, sck}, 32'h0);
        chk("R1 mosi idle", {31'b0, mosi}, 32'h0);
        rd_chk("R11 unmapped", 5'h0C, 32'h0);

        // R10 start ignored while disabled
        wr(5'h14, 32'h9000_0008);
        repeat (3) @(negedge clk);
        rd_chk("R10 no busy when disabled", 5'h14, 32'h1000_0008);
        chk("R10 cs idle when disabled", {29'b0, cs_n}, 32'h7);

        wr(5'h00, 32'h1);
        rd_chk("R11 enable readback", 5'h00, 32'h1);
        cur_div = 6'd0; wr(5'h04, 32'h0);
        cur_dout = 32'h0000_00A5; wr(5'h10, cur_dout);
        rd_chk("R11 dout readback", 5'h10, cur_dout);
        run_shift(32'h9000_0008, 32'h0000_003C, 3'b001, 1'b0);   // R7 hold

        cur_div = 6'd2; wr(5'h04, 32'h2);
        rd_chk("R11 div readback", 5'h04, 32'h2);
        cur_dout = 32'h0000_BEEF; wr(5'h10, cur_dout);
        run_shift(32'h9400_0010, 32'h0000_5AC3, 3'b001, 1'b0);   // R7 release

        cur_div = 6'd1; wr(5'h04, 32'h1);
        cur_dout = 32'h0012_3456; wr(5'h10, cur_dout);
        run_shift(32'hA000_0018, 32'h00C0_FFEE, 3'b010, 1'b1);   // R9

        cur_div = 6'd0; wr(5'h04, 32'h0);
        cur_dout = 32'hDEAD_BEEF; wr(5'h10, cur_dout);
        run_shift(32'hC400_0000, 32'h8765_4321, 3'b100, 1'b0);   // R8 count 0

        cur_dout = 32'h0F0F_1234; wr(5'h10, cur_dout);
        run_shift(32'h9400_0028, 32'hF00D_CAFE, 3'b001, 1'b0);   // R8 count 40

        // R10 abort mid-shift
        cur_div = 6'd3; wr(5'h04, 32'h3);
        wr(5'h14, 32'h9000_0008);
        repeat (5) @(negedge clk);
        chk("R10 shift running", {29'b0, cs_n}, 32'h6);
        wr(5'h00, 32'h0);
        rd_chk("R10 abort clears busy", 5'h14, 32'h1000_0008);
        chk("R10 abort releases cs", {29'b0, cs_n}, 32'h7);
        chk("R10 abort sck idle", {31'b0, sck}, 32'h0);

        // R1 idle pins follow ioctl
        wr(5'h08, 32'h0005_0101);
        rd_chk("R11 ioctl readback", 5'h08, 32'h0005_0101);
        chk("R1 ioctl mosi", {31'b0, mosi}, 32'h1);
        chk("R1 ioctl sck", {31'b0, sck}, 32'h1);
        chk("R1 ioctl cs", {29'b0, cs_n}, 32'h5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule